// File: doc/BRIEF.md
# SPI Configuration Register Slave

This block is a serial-peripheral-interface slave that owns a small byte-wide configuration register file for a clock-synthesis subsystem. An external host selects it with an active-low chip select and clocks in a command byte. The command byte carries a 7-bit register address, most significant bit first, and a final direction bit. Data bytes then stream in or out. After every complete data byte the address moves on by one, so a single transaction can program or dump a whole run of registers.

The register file holds three kinds of register. One is a power control register whose bit 5 requests the low-current hibernate state. One is an output control register that carries an enable and a 3-bit drive strength for each of two clock outputs. Five divider bytes hold the fractional feedback value and the two output dividers. Every register is exported to the rest of the chip continuously. The SPI pins are brought into the system clock domain by flop synchronizers, and the whole block runs on that one clock. The host's serial clock must therefore be slow compared with the system clock: each SCLK phase has to last at least four system clock cycles.

Top module: `spi_cfg_slave`

## Requirements
- R1: The first byte after chip select falls is the command: bits 7..1 are the address (MSB first on the wire) and bit 0, the last bit sent, is the direction, 1 for read and 0 for write.
- R2: In a write, each complete data byte is stored at the current address, and the address then advances by one, so byte k lands at address+k.
- R3: In a read, MISO presents the byte at address+k, MSB first. Each bit changes after a falling SCLK edge and is valid at the next rising edge, starting with the falling edge that follows the command's last bit. MOSI data during a read changes no register.
- R4: While chip select is high, spi_miso_oe is low and SCLK and MOSI activity changes no register.
- R5: Chip select rising before a byte is complete discards that partial byte and clears the bit count, so the next transaction decodes a fresh command.
- R6: Address 0x10 is the power register, and its bit 5 drives cfg_hibernate. Address 0x11 holds out2 drive in bits 7..5, out2 enable in bit 4, out1 drive in bits 3..1 and out1 enable in bit 0. Addresses 0x13..0x17 are divider bytes 0..4, with byte i on cfg_div[8i+7:8i].
- R7: After reset the power register is 0x00, the output control register is 0xFF (both outputs enabled at drive 111), every divider byte is 0x00 and spi_miso_oe is low.
- R8: Writes to any address outside 0x10, 0x11 and 0x13..0x17 (including 0x12) are dropped, and reads from them return 0x00. Auto-increment still steps across such addresses.
- R9: The pins pass through two synchronizer flops: spi_miso_oe follows a chip-select change at the third rising clk edge after it, and a written byte is visible on the exports within five clk cycles after the rising SCLK edge of its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad |
| cfg_hib_reg | output | 8 | Power control register (0x10) |
| cfg_hibernate | output | 1 | Hibernate request (bit 5 of 0x10) |
| cfg_out1_en | output | 1 | Output 1 enable |
| cfg_out1_drive | output | 3 | Output 1 drive strength |
| cfg_out2_en | output | 1 | Output 2 enable |
| cfg_out2_drive | output | 3 | Output 2 drive strength |
| cfg_div | output | 40 | Divider bytes 0..4 (0x13..0x17) |

## Verification
An SCLK edge is acted on three clk cycles after the pin moves, because it passes two synchronizer flops and then an edge detector. A MISO bit is therefore settled about three cycles after a falling edge. The bench holds each SCLK phase for eight cycles and samples MISO at the following rising edge. Register exports update one cycle after the internal write strobe, and the bench reads them only after chip select has been raised again. The enable output is checked exactly three edges after chip select moves, which is the latency R9 states.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int NUM_DIV  = 5;
  localparam int SYNC_LEN = 2;
  localparam logic [ADDR_W-1:0] HIB_ADDR = 7'h10;
  localparam logic [ADDR_W-1:0] OUT_ADDR = 7'h11;
  localparam logic [ADDR_W-1:0] DIV_BASE = 7'h13;
  localparam logic [DATA_W-1:0] HIB_RST  = 8'h00;
  localparam logic [DATA_W-1:0] OUT_RST  = 8'hFF;
  localparam int HIB_BIT = 5;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sclk,
  input  logic              mosi,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso,
  output logic              miso_oe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              sclk_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] sh_in;
  logic              in_data;
  logic              is_read;
  logic              load_pend;
  logic [DATA_W-1:0] tx_sr;
  logic              rise, fall;

  assign rise = cs_act &  sclk & ~sclk_q;
  assign fall = cs_act & ~sclk &  sclk_q;
  assign miso = tx_sr[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      bit_cnt   <= '0;
      sh_in     <= '0;
      in_data   <= 1'b0;
      is_read   <= 1'b0;
      load_pend <= 1'b0;
      tx_sr     <= '0;
      cur_addr  <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      miso_oe   <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      wr_en   <= 1'b0;
      miso_oe <= cs_act;
      if (!cs_act) begin
        bit_cnt   <= '0;
        in_data   <= 1'b0;
        load_pend <= 1'b0;
        tx_sr     <= '0;
      end else begin
        if (rise) begin
          sh_in   <= {sh_in[DATA_W-3:0], mosi};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            if (!in_data) begin
              cur_addr  <= sh_in[ADDR_W-1:0];
              is_read   <= mosi;
              load_pend <= mosi;
              in_data   <= 1'b1;
            end else if (is_read) begin
              cur_addr  <= cur_addr + 1'b1;
              load_pend <= 1'b1;
            end else begin
              wr_en    <= 1'b1;
              wr_addr  <= cur_addr;
              wr_data  <= {sh_in, mosi};
              cur_addr <= cur_addr + 1'b1;
            end
          end
        end
        if (fall) begin
          if (load_pend) begin
            tx_sr     <= rd_data;
            load_pend <= 1'b0;
          end else begin
            tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int NUM_DIV = 5,
  parameter logic [ADDR_W-1:0] HIB_ADDR = 7'h10,
  parameter logic [ADDR_W-1:0] OUT_ADDR = 7'h11,
  parameter logic [ADDR_W-1:0] DIV_BASE = 7'h13,
  parameter logic [DATA_W-1:0] HIB_RST = 8'h00,
  parameter logic [DATA_W-1:0] OUT_RST = 8'hFF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic [DATA_W-1:0]         hib_q,
  output logic [DATA_W-1:0]         out_q,
  output logic [NUM_DIV*DATA_W-1:0] div_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hib_q <= HIB_RST;
      out_q <= OUT_RST;
    end else if (wr_en) begin
      if (wr_addr == HIB_ADDR) hib_q <= wr_data;
      if (wr_addr == OUT_ADDR) out_q <= wr_data;
    end
  end

  generate
    for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DIV_BASE + i);
      always_ff @(posedge clk) begin
        if (rst) div_q[i*DATA_W +: DATA_W] <= '0;
        else if (wr_en && wr_addr == MY_ADDR) div_q[i*DATA_W +: DATA_W] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (rd_addr == HIB_ADDR) rd_data = hib_q;
    if (rd_addr == OUT_ADDR) rd_data = out_q;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (rd_addr == ADDR_W'(DIV_BASE + i)) rd_data = div_q[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W,
  parameter int P_NUM_DIV = NUM_DIV,
  parameter int P_SYNC = SYNC_LEN
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          spi_cs_n,
  input  logic                          spi_sclk,
  input  logic                          spi_mosi,
  output logic                          spi_miso,
  output logic                          spi_miso_oe,
  output logic [P_DATA_W-1:0]           cfg_hib_reg,
  output logic                          cfg_hibernate,
  output logic                          cfg_out1_en,
  output logic [2:0]                    cfg_out1_drive,
  output logic                          cfg_out2_en,
  output logic [2:0]                    cfg_out2_drive,
  output logic [P_NUM_DIV*P_DATA_W-1:0] cfg_div
);
  logic [2:0]          pins_s;
  logic                cs_act;
  logic [P_ADDR_W-1:0] cur_addr;
  logic                wr_en;
  logic [P_ADDR_W-1:0] wr_addr;
  logic [P_DATA_W-1:0] wr_data;
  logic [P_DATA_W-1:0] rd_data;
  logic [P_DATA_W-1:0] out_q;

  spi_pin_sync #(.WIDTH(3), .STAGES(P_SYNC), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_cs_n, spi_sclk, spi_mosi}),
    .q(pins_s)
  );

  assign cs_act = ~pins_s[2];

  spi_byte_engine #(.ADDR_W(P_ADDR_W), .DATA_W(P_DATA_W)) u_eng (
    .clk(clk), .rst(rst), .cs_act(cs_act),
    .sclk(pins_s[1]), .mosi(pins_s[0]),
    .rd_data(rd_data), .cur_addr(cur_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_cfg_regs #(
    .ADDR_W(P_ADDR_W), .DATA_W(P_DATA_W), .NUM_DIV(P_NUM_DIV),
    .HIB_ADDR(HIB_ADDR), .OUT_ADDR(OUT_ADDR), .DIV_BASE(DIV_BASE),
    .HIB_RST(HIB_RST), .OUT_RST(OUT_RST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(cur_addr), .rd_data(rd_data),
    .hib_q(cfg_hib_reg), .out_q(out_q), .div_q(cfg_div)
  );

  assign cfg_hibernate  = cfg_hib_reg[HIB_BIT];
  assign cfg_out2_drive = out_q[7:5];
  assign cfg_out2_en    = out_q[4];
  assign cfg_out1_drive = out_q[3:1];
  assign cfg_out1_en    = out_q[0];
endmodule

// File: rtl/spi_cfg_checker.sv
module spi_cfg_checker #(
  parameter int AW = 7,
  parameter int CW = 40
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_act,
  input logic          spi_miso_oe,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    cfg_hib_reg,
  input logic [2:0]    cfg_out1_drive,
  input logic [2:0]    cfg_out2_drive,
  input logic          cfg_out1_en,
  input logic          cfg_out2_en,
  input logic [CW-1:0] cfg_div
);
  logic implemented;
  assign implemented = (wr_addr == 7'h10) || (wr_addr == 7'h11) ||
                       (wr_addr >= 7'h13 && wr_addr <= 7'h17);

  // R4
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !spi_miso_oe);

  // R4
  no_write_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_act && $past(!cs_act)) |-> !wr_en);

  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_div));

  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(cfg_hib_reg) && $stable({cfg_out2_drive, cfg_out2_en, cfg_out1_drive, cfg_out1_en})));

  // R8
  drop_unimpl_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !implemented) |=> ($stable(cfg_div) && $stable(cfg_hib_reg) &&
      $stable({cfg_out2_drive, cfg_out2_en, cfg_out1_drive, cfg_out1_en})));
endmodule

bind spi_cfg_slave spi_cfg_checker #(.AW(P_ADDR_W), .CW(P_NUM_DIV*P_DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .spi_miso_oe(spi_miso_oe),
  .wr_en(wr_en), .wr_addr(wr_addr), .cfg_hib_reg(cfg_hib_reg),
  .cfg_out1_drive(cfg_out1_drive), .cfg_out2_drive(cfg_out2_drive),
  .cfg_out1_en(cfg_out1_en), .cfg_out2_en(cfg_out2_en), .cfg_div(cfg_div)
);

// File: tb/tb_spi_cfg_slave.sv
module tb_spi_cfg_slave;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_cs_n = 1'b1;
  logic spi_sclk = 1'b0;
  logic spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic [7:0] cfg_hib_reg;
  logic cfg_hibernate, cfg_out1_en, cfg_out2_en;
  logic [2:0] cfg_out1_drive, cfg_out2_drive;
  logic [39:0] cfg_div;

  always #2 clk = ~clk;

  spi_cfg_slave dut (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .cfg_hib_reg(cfg_hib_reg), .cfg_hibernate(cfg_hibernate),
    .cfg_out1_en(cfg_out1_en), .cfg_out1_drive(cfg_out1_drive),
    .cfg_out2_en(cfg_out2_en), .cfg_out2_drive(cfg_out2_drive),
    .cfg_div(cfg_div)
  );

  int total = 0;
  int failed = 0;

  typedef struct packed { logic [6:0] a; logic [7:0] v; } exp_t;
  exp_t exp_q[$];
  logic [7:0] model [128];
  logic [7:0] wbuf [16];

  logic       mon_on = 1'b0;
  int         mon_cnt = 0;
  logic [7:0] mon_byte = '0;

  function automatic bit impl(input logic [6:0] a);
    return (a == 7'h10) || (a == 7'h11) || (a >= 7'h13 && a <= 7'h17);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read bytes and compares MISO as it streams
  always @(posedge spi_sclk) begin
    if (mon_on) begin
      mon_byte = {mon_byte[6:0], spi_miso};
      mon_cnt++;
      if (mon_cnt == 8) begin
        exp_t e;
        mon_cnt = 0;
        total++;
        if (exp_q.size() == 0) begin
          failed++;
          $display("FAIL R3 unexpected read byte actual=%0h expected=none", mon_byte);
        end else begin
          e = exp_q.pop_front();
          if (mon_byte !== e.v) begin
            failed++;
            if (impl(e.a)) $display("FAIL R3 addr %0h actual=%0h expected=%0h", e.a, mon_byte, e.v);
            else           $display("FAIL R8 addr %0h actual=%0h expected=%0h", e.a, mon_byte, e.v);
          end
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi = b[i];
      wait_clk(HALF);
      spi_sclk = 1'b1;
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_high();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  // driver: write burst, updating the bench model per R2/R8
  task automatic spi_write(input logic [6:0] addr, input int n);
    cs_low();
    send_bits({addr, 1'b0}, 8);
    for (int k = 0; k < n; k++) begin
      logic [6:0] a;
      a = addr + 7'(k);
      send_bits(wbuf[k], 8);
      if (impl(a)) model[a] = wbuf[k];
    end
    cs_high();
  endtask

  // driver: read burst, pushing expected bytes to the scoreboard
  task automatic spi_read(input logic [6:0] addr, input int n, input logic [7:0] junk);
    cs_low();
    send_bits({addr, 1'b1}, 8);
    for (int k = 0; k < n; k++) begin
      logic [6:0] a;
      exp_t e;
      a = addr + 7'(k);
      e.a = a;
      e.v = model[a];
      exp_q.push_back(e);
    end
    mon_on = 1'b1;
    for (int k = 0; k < n; k++) send_bits(junk, 8);
    mon_on = 1'b0;
    cs_high();
  endtask

  task automatic check_exports(input string tag);
    chk(tag, cfg_hib_reg, model[7'h10]);
    chk(tag, {cfg_out2_drive, cfg_out2_en, cfg_out1_drive, cfg_out1_en}, model[7'h11]);
    chk(tag, cfg_div, {model[7'h17], model[7'h16], model[7'h15], model[7'h14], model[7'h13]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    model[7'h11] = 8'hFF;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);

    // R7 reset state
    chk("R7 oe", spi_miso_oe, 1'b0);
    chk("R7 hibernate", cfg_hibernate, 1'b0);
    chk("R7 out drives", {cfg_out2_drive, cfg_out1_drive}, 6'b111111);
    chk("R7 out enables", {cfg_out2_en, cfg_out1_en}, 2'b11);
    chk("R7 dividers", cfg_div, 40'h0);

    // R9 enable latency, R4 release
    spi_cs_n = 1'b0;
    wait_clk(3);
    chk("R9 oe after cs low", spi_miso_oe, 1'b1);
    spi_cs_n = 1'b1;
    wait_clk(3);
    chk("R4 oe after cs high", spi_miso_oe, 1'b0);
    wait_clk(4);

    // R2 R6 divider burst
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44; wbuf[4] = 8'h55;
    spi_write(7'h13, 5);
    chk("R2 R6 divider order", cfg_div, 40'h5544332211);

    // R2 R6 control registers via burst from 0x10
    wbuf[0] = 8'h20; wbuf[1] = 8'hA5;
    spi_write(7'h10, 2);
    chk("R6 hibernate", cfg_hibernate, 1'b1);
    chk("R6 out2 drive", cfg_out2_drive, 3'b101);
    chk("R6 out2 en", cfg_out2_en, 1'b0);
    chk("R6 out1 drive", cfg_out1_drive, 3'b010);
    chk("R6 out1 en", cfg_out1_en, 1'b1);

    // R8 write to 0x12 dropped, increment continues to 0x13
    wbuf[0] = 8'h77; wbuf[1] = 8'h99;
    spi_write(7'h12, 2);
    check_exports("R8 hole write");

    // R1 R3 R8 read burst spanning unimplemented addresses
    spi_read(7'h0F, 10, 8'h00);

    // R3 MOSI ignored during read
    spi_read(7'h13, 3, 8'hFF);
    check_exports("R3 mosi ignored");

    // R5 abort mid data byte
    cs_low();
    send_bits({7'h14, 1'b0}, 8);
    send_bits(8'hF0, 4);
    cs_high();
    check_exports("R5 partial data dropped");

    // R5 abort mid command, then fresh write decodes correctly
    cs_low();
    send_bits(8'hFF, 5);
    cs_high();
    wbuf[0] = 8'h3C;
    spi_write(7'h14, 1);
    check_exports("R5 fresh command");

    // R4 clocking while deselected has no effect
    for (int i = 0; i < 16; i++) begin
      spi_mosi = i[0];
      wait_clk(4);
      spi_sclk = ~spi_sclk;
      wait_clk(4);
    end
    spi_sclk = 1'b0;
    chk("R4 oe idle", spi_miso_oe, 1'b0);
    check_exports("R4 idle sclk");
    spi_read(7'h10, 8, 8'h00);

    wait_clk(10);
    if (exp_q.size() != 0) chk("R3 leftover", exp_q.size(), 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule